// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers interrupt requests from 32 primary sources and 32 secondary sources and turns them into one CPU interrupt line plus a ready-made vector. Three primary bits do not come from pins. Each one is the OR of one fixed range of the secondary level after that level's own mask. Software therefore sees a cascade: the primary level points at a group, and the secondary level names the exact source.

Every source bit has a fixed type, set by a parameter. An edge bit latches on a rising edge of its synchronised input and holds until software clears it. A level bit simply follows its synchronised input. Three primary edge bits can also be raised by software.

Software reaches the registers through a single-cycle bus. A write takes effect at the clock edge on which it is presented. A read returns data in the same cycle.

Register addresses (`bus_addr`):
- 0: primary status, read-only.
- 1: primary mask.
- 2: primary latched edges. Writing 0 to a bit clears it; writing 1 leaves it alone.
- 3: software requests.
- 4: secondary status. Writing clears secondary edge bits the same way as address 2.
- 5: secondary mask.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, these all read 0 while every source is held low: primary mask (address 1), latched edges (address 2), software register (address 3), secondary status (address 4) and secondary mask (address 5). `cpu_irq` and `disp_vld` are 0.
- R2: A level-type primary bit follows its synchronised source within a few cycles and is not held after the source falls.
- R3: Primary bits 16-19, 22-24 and 28-31 are edge type. Such a bit sets on a 0-to-1 change of its synchronised source and stays set after the source returns low.
- R4: Writing address 2 clears exactly the edge bits written as 0. Edge bits written as 1 keep their value.
- R5: If a new rising edge on a bit coincides with the clock edge of a write that clears that bit, the bit stays set. The other bits cleared by the same write still clear.
- R6: Address 3 stores only bits 28-30. Software setting one of these bits from 0 to 1 latches the matching primary edge bit. Setting bit 31 there has no effect.
- R7: Primary bit 4 is the OR of (secondary status AND secondary mask) over secondary bits 16-31. Bit 5 covers secondary bits 8-15, and bit 6 covers secondary bits 0-7.
- R8: Secondary bits 16, 22 and 28 are edge type: they latch and hold. Writing address 4 with such a bit at 0 clears it.
- R9: Primary pending is status AND mask. `cpu_irq` is a register holding the OR of the pending bits. It falls one cycle after a mask write removes the last pending bit.
- R10: With primary pending equal to 0, `cpu_irq` stays 0 and `disp_vld` is 0, even when masked-off sources are active.
- R11: Without a pending summary bit, `disp_vec` is {0, index of the lowest pending primary bit}. `pri_vec` carries the same index.
- R12: If any of primary bits 4-6 is pending, `disp_vec` is {1, index of the lowest bit of secondary status AND secondary mask}, even when a lower primary bit is also pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pri_src | input | 32 | Asynchronous primary requests (bits 4-6 unused) |
| sec_src | input | 32 | Asynchronous secondary requests |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| cpu_irq | output | 1 | Registered CPU interrupt request |
| pri_vec | output | 5 | Lowest pending primary bit |
| pri_vld | output | 1 | Some primary bit pending |
| sec_vec | output | 5 | Lowest pending secondary bit |
| sec_vld | output | 1 | Some secondary bit pending |
| disp_vec | output | 6 | Dispatch vector: level flag and index |
| disp_vld | output | 1 | Dispatch vector valid |

## Verification
Two functions can fall in the same cycle: a fresh rising edge on a latched primary bit, and a software write that clears that bit. The bench counts the synchroniser and edge-detect registers so that the clearing write is sampled on exactly the clock edge where the edge is detected. That write also clears a different, older latched bit. The result is judged by reading address 2: the new bit must still be set and the older bit must be gone.

// File: rtl/cic_pkg.sv
package cic_pkg;
   localparam int CIC_ADDR_W = 3;
   localparam int CIC_NGRP   = 3;

   typedef enum logic [CIC_ADDR_W-1:0] {
      REG_PSTAT = 3'd0,
      REG_PMASK = 3'd1,
      REG_PEDGE = 3'd2,
      REG_SOFT  = 3'd3,
      REG_SSTAT = 3'd4,
      REG_SMASK = 3'd5
   } cic_reg_e;

   // secondary ranges and the primary summary bit each one drives
   localparam logic [31:0] SEC_GRP [CIC_NGRP] = '{32'hFFFF_0000, 32'h0000_FF00, 32'h0000_00FF};
   localparam int          SUM_POS [CIC_NGRP] = '{4, 5, 6};
   localparam logic [31:0] SUM_MASK = 32'h0000_0070;
endpackage

// File: rtl/cic_sync.sv
module cic_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad
      $error("cic_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cic_src_bank.sv
module cic_src_bank #(
   parameter int           W         = 32,
   parameter logic [W-1:0] EDGE_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] clr,
   output logic [W-1:0] stat
);
   logic [W-1:0] prev_q;
   logic [W-1:0] latch_q;
   logic [W-1:0] rise;

   assign rise = lvl & ~prev_q & EDGE_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         latch_q <= '0;
      end else begin
         prev_q  <= lvl & EDGE_MASK;
         // a detected edge outranks a clear in the same cycle
         latch_q <= ((latch_q & ~clr) | rise) & EDGE_MASK;
      end
   end

   assign stat = (latch_q & EDGE_MASK) | (lvl & ~EDGE_MASK);
endmodule

// File: rtl/cic_lowest.sv
module cic_lowest #(
   parameter int W  = 32,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          vld
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign vld = |req;
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
   import cic_pkg::*;
#(
   parameter int              SRC_W       = 32,
   parameter int              SYNC_STAGES = 2,
   parameter logic [SRC_W-1:0] PRI_EDGE   = 32'hF1CF_0000,
   parameter logic [SRC_W-1:0] SEC_EDGE   = 32'h1041_0000,
   parameter logic [SRC_W-1:0] SOFT_BITS  = 32'h7000_0000,
   localparam int             IW          = $clog2(SRC_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SRC_W-1:0]      pri_src,
   input  logic [SRC_W-1:0]      sec_src,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [CIC_ADDR_W-1:0] bus_addr,
   input  logic [SRC_W-1:0]      bus_wdata,
   output logic [SRC_W-1:0]      bus_rdata,
   output logic                  cpu_irq,
   output logic [IW-1:0]         pri_vec,
   output logic                  pri_vld,
   output logic [IW-1:0]         sec_vec,
   output logic                  sec_vld,
   output logic [IW:0]           disp_vec,
   output logic                  disp_vld
);
   if (SRC_W != 32) begin : g_bad_w
      $error("casc_irq_ctrl: group ranges are defined for 32 sources");
   end
   if ((PRI_EDGE & SUM_MASK) != '0) begin : g_bad_edge
      $error("casc_irq_ctrl: summary bits must be level type");
   end
   if ((SOFT_BITS & ~PRI_EDGE) != '0) begin : g_bad_soft
      $error("casc_irq_ctrl: software bits must be edge type");
   end

   logic                 wr_en;
   logic [SRC_W-1:0]     pri_mask, sec_mask, soft_q;
   logic [SRC_W-1:0]     pri_sync, sec_sync;
   logic [SRC_W-1:0]     pri_stat, sec_stat;
   logic [SRC_W-1:0]     pri_pend, sec_pend;
   logic [SRC_W-1:0]     pri_clr, sec_clr;
   logic [SRC_W-1:0]     sum_vec, pri_lvl;
   logic                 irq_q;
   logic                 sum_hit;

   assign wr_en = bus_sel & bus_wr;

   // ---------------- register file ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_mask <= '0;
         sec_mask <= '0;
         soft_q   <= '0;
      end else if (wr_en) begin
         case (cic_reg_e'(bus_addr))
            REG_PMASK: pri_mask <= bus_wdata;
            REG_SMASK: sec_mask <= bus_wdata;
            REG_SOFT:  soft_q   <= bus_wdata & SOFT_BITS;
            default: ;
         endcase
      end
   end

   assign pri_clr = (wr_en && cic_reg_e'(bus_addr) == REG_PEDGE) ? ~bus_wdata : '0;
   assign sec_clr = (wr_en && cic_reg_e'(bus_addr) == REG_SSTAT) ? ~bus_wdata : '0;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         case (cic_reg_e'(bus_addr))
            REG_PSTAT: bus_rdata = pri_stat;
            REG_PMASK: bus_rdata = pri_mask;
            REG_PEDGE: bus_rdata = pri_stat & PRI_EDGE;
            REG_SOFT:  bus_rdata = soft_q;
            REG_SSTAT: bus_rdata = sec_stat;
            REG_SMASK: bus_rdata = sec_mask;
            default:   bus_rdata = '0;
         endcase
      end
   end

   // ---------------- synchronisers ----------------
   cic_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_pri_sync (
      .clk(clk), .rst_n(rst_n), .d(pri_src & ~SUM_MASK), .q(pri_sync)
   );
   cic_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sec_sync (
      .clk(clk), .rst_n(rst_n), .d(sec_src), .q(sec_sync)
   );

   // ---------------- secondary level ----------------
   cic_src_bank #(.W(SRC_W), .EDGE_MASK(SEC_EDGE)) u_sec_bank (
      .clk(clk), .rst_n(rst_n), .lvl(sec_sync), .clr(sec_clr), .stat(sec_stat)
   );
   assign sec_pend = sec_stat & sec_mask;

   always_comb begin
      sum_vec = '0;
      for (int g = 0; g < CIC_NGRP; g++) begin
         sum_vec[SUM_POS[g]] = |(sec_pend & SEC_GRP[g]);
      end
   end

   // ---------------- primary level ----------------
   assign pri_lvl = pri_sync | soft_q | sum_vec;

   cic_src_bank #(.W(SRC_W), .EDGE_MASK(PRI_EDGE)) u_pri_bank (
      .clk(clk), .rst_n(rst_n), .lvl(pri_lvl), .clr(pri_clr), .stat(pri_stat)
   );
   assign pri_pend = pri_stat & pri_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pri_pend;
   end
   assign cpu_irq = irq_q;

   // ---------------- vectors ----------------
   cic_lowest #(.W(SRC_W)) u_pri_low (.req(pri_pend), .idx(pri_vec), .vld(pri_vld));
   cic_lowest #(.W(SRC_W)) u_sec_low (.req(sec_pend), .idx(sec_vec), .vld(sec_vld));

   assign sum_hit  = |(pri_pend & SUM_MASK);
   assign disp_vec = sum_hit ? {1'b1, sec_vec} : {1'b0, pri_vec};
   assign disp_vld = sum_hit ? sec_vld : pri_vld;
endmodule

// File: rtl/casc_irq_ctrl_chk.sv
module casc_irq_ctrl_chk
   import cic_pkg::*;
#(
   parameter int           W        = 32,
   parameter logic [W-1:0] PRI_EDGE = '0,
   parameter logic [W-1:0] SEC_EDGE = '0,
   localparam int          IW       = $clog2(W)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_sel,
   input logic                  bus_wr,
   input logic [CIC_ADDR_W-1:0] bus_addr,
   input logic [W-1:0]          bus_wdata,
   input logic                  cpu_irq,
   input logic [IW:0]           disp_vec,
   input logic                  disp_vld,
   input logic [W-1:0]          pri_stat,
   input logic [W-1:0]          pri_mask,
   input logic [W-1:0]          sec_stat,
   input logic [W-1:0]          sec_mask
);
   logic [W-1:0] pend, spend, pwipe, swipe;
   assign pend  = pri_stat & pri_mask;
   assign spend = sec_stat & sec_mask;
   assign pwipe = (bus_sel && bus_wr && bus_addr == REG_PEDGE) ? ~bus_wdata : '0;
   assign swipe = (bus_sel && bus_wr && bus_addr == REG_SSTAT) ? ~bus_wdata : '0;

   // R3/R4: a latched primary edge bit only drops under a clearing write
   assert_pri_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(pri_stat) & PRI_EDGE & ~$past(pwipe)) & ~pri_stat) == '0));

   // R8: same for secondary edge bits
   assert_sec_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(sec_stat) & SEC_EDGE & ~$past(swipe)) & ~sec_stat) == '0));

   // R7: summary bits track the masked secondary groups
   assert_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_stat[4] == |(spend & SEC_GRP[0])) && (pri_stat[5] == |(spend & SEC_GRP[1]))
      && (pri_stat[6] == |(spend & SEC_GRP[2])));

   // R9: registered request rises and falls one cycle behind pending
   assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |=> cpu_irq);
   assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> !cpu_irq);

   // R10: nothing pending means no vector
   assert_no_spurious_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> !disp_vld);

   // R11: primary vector names the lowest pending bit
   assert_lowest_pri_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_vld && !disp_vec[IW]) |->
         (pend[disp_vec[IW-1:0]] && ((pend & ((W'(1) << disp_vec[IW-1:0]) - W'(1))) == '0)));

   // R12: pending summary diverts dispatch to the secondary level
   assert_sec_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & SUM_MASK) != '0) |-> (disp_vld && disp_vec[IW] && spend[disp_vec[IW-1:0]]));
endmodule

bind casc_irq_ctrl casc_irq_ctrl_chk #(
   .W(SRC_W), .PRI_EDGE(PRI_EDGE), .SEC_EDGE(SEC_EDGE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .cpu_irq(cpu_irq), .disp_vec(disp_vec), .disp_vld(disp_vld),
   .pri_stat(pri_stat), .pri_mask(pri_mask), .sec_stat(sec_stat), .sec_mask(sec_mask)
);

// File: tb/casc_irq_ctrl_tb.sv
module casc_irq_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] pri_src, sec_src;
   logic        bus_sel, bus_wr;
   logic [2:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        cpu_irq, pri_vld, sec_vld, disp_vld;
   logic [4:0]  pri_vec, sec_vec;
   logic [5:0]  disp_vec;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   casc_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pri_src(pri_src), .sec_src(sec_src),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .pri_vec(pri_vec), .pri_vld(pri_vld),
      .sec_vec(sec_vec), .sec_vld(sec_vld), .disp_vec(disp_vec), .disp_vld(disp_vld)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; pri_src = '0; sec_src = '0;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      repeat (5) @(posedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      for (int a = 1; a <= 5; a++) begin
         rd(3'(a), v);
         check($sformatf("R1 reg %0d after reset", a), v, 32'h0);
      end
      check("R1 cpu_irq after reset", {31'b0, cpu_irq}, 32'h0);
      check("R1 disp_vld after reset", {31'b0, disp_vld}, 32'h0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      do_reset();
      pri_src[3] = 1'b1; settle();
      rd(3'd0, v); check("R2 level bit high", v, 32'h0000_0008);
      pri_src[3] = 1'b0; settle();
      rd(3'd0, v); check("R2 level bit not held", v, 32'h0);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      do_reset();
      pri_src[16] = 1'b1; pri_src[17] = 1'b1; settle();
      pri_src[16] = 1'b0; pri_src[17] = 1'b0; settle();
      rd(3'd2, v); check("R3 edges latched after source low", v, 32'h0003_0000);
      wr(3'd2, 32'hFFFE_FFFF);
      rd(3'd2, v); check("R4 clear one bit keeps other", v, 32'h0002_0000);
      wr(3'd2, 32'h0);
      rd(3'd2, v); check("R4 clear all", v, 32'h0);
   endtask

   task automatic t_same_cycle();
      logic [31:0] v;
      do_reset();
      pri_src[17] = 1'b1; settle(); pri_src[17] = 1'b0; settle();
      @(negedge clk) pri_src[16] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h0;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      rd(3'd2, v); check("R5 edge wins over same-cycle clear", v, 32'h0001_0000);
   endtask

   task automatic t_soft();
      logic [31:0] v;
      do_reset();
      wr(3'd3, 32'h1000_0000); settle();
      rd(3'd2, v); check("R6 software bit latches edge", v, 32'h1000_0000);
      rd(3'd3, v); check("R6 software register readback", v, 32'h1000_0000);
      wr(3'd2, 32'h0);
      rd(3'd2, v); check("R6 held software bit does not relatch", v, 32'h0);
      wr(3'd3, 32'h8000_0000); settle();
      rd(3'd2, v); check("R6 bit 31 write no effect on edges", v, 32'h0);
      rd(3'd3, v); check("R6 bit 31 not stored", v, 32'h0);
   endtask

   task automatic t_irq_timing();
      do_reset();
      pri_src[3] = 1'b1; settle();
      check("R10 masked-off source no irq", {31'b0, cpu_irq}, 32'h0);
      check("R10 masked-off source no vector", {31'b0, disp_vld}, 32'h0);
      wr(3'd1, 32'h0000_0008); settle();
      check("R9 irq raised", {31'b0, cpu_irq}, 32'h1);
      check("R11 vector for bit 3", {25'b0, disp_vld, disp_vec}, {25'b0, 1'b1, 6'd3});
      wr(3'd1, 32'h0);
      check("R9 irq still high in cycle after mask write", {31'b0, cpu_irq}, 32'h1);
      check("R10 vector gone at once", {31'b0, disp_vld}, 32'h0);
      @(negedge clk);
      check("R9 irq low one cycle later", {31'b0, cpu_irq}, 32'h0);
   endtask

   task automatic t_dispatch();
      do_reset();
      pri_src[9] = 1'b1; pri_src[3] = 1'b1; settle();
      wr(3'd1, 32'h0000_0208); @(negedge clk);
      check("R11 lowest of 3 and 9", {26'b0, disp_vec}, 32'd3);
      check("R11 pri_vec", {27'b0, pri_vec}, 32'd3);
      wr(3'd1, 32'h0000_0200); @(negedge clk);
      check("R11 only 9 masked in", {26'b0, disp_vec}, 32'd9);
   endtask

   task automatic t_secondary();
      logic [31:0] v;
      do_reset();
      sec_src[10] = 1'b1; pri_src[3] = 1'b1;
      wr(3'd5, 32'h0000_0400);
      wr(3'd1, 32'h0000_0068 | 32'h0000_0010);
      settle();
      rd(3'd0, v); check("R7 group 8-15 sets bit 5", v, 32'h0000_0028);
      check("R12 secondary overrides lower bit 3", {26'b0, disp_vec}, {26'b0, 6'd42});
      check("R12 sec_vec", {27'b0, sec_vec}, 32'd10);
      sec_src[2] = 1'b1; wr(3'd5, 32'h0000_0404); settle();
      rd(3'd0, v); check("R7 group 0-7 sets bit 6", v, 32'h0000_0068);
      check("R12 lowest secondary bit 2", {26'b0, disp_vec}, {26'b0, 6'd34});
      wr(3'd5, 32'h0); @(negedge clk);
      rd(3'd0, v); check("R7 secondary mask clears summaries", v, 32'h0000_0008);
      check("R11 back to primary vector", {26'b0, disp_vec}, 32'd3);
   endtask

   task automatic t_sec_edge();
      logic [31:0] v;
      do_reset();
      sec_src[22] = 1'b1; settle(); sec_src[22] = 1'b0; settle();
      rd(3'd4, v); check("R8 secondary edge held", v, 32'h0040_0000);
      wr(3'd5, 32'h0040_0000); wr(3'd1, 32'h0000_0010); @(negedge clk);
      rd(3'd0, v); check("R7 group 16-31 sets bit 4", v, 32'h0000_0010);
      wr(3'd4, 32'h0);
      rd(3'd4, v); check("R8 secondary edge cleared", v, 32'h0);
      rd(3'd0, v); check("R8 summary drops with it", v, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_level();
      t_edge();
      t_same_cycle();
      t_soft();
      t_irq_timing();
      t_dispatch();
      t_secondary();
      t_sec_edge();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule